// File: doc/BRIEF.md
# Regulator Health Supervisor

This block watches a buck regulator from the digital side. Each clock it compares a digitized feedback code against the current reference code. It also counts peak-current-limit trips per switching cycle and follows an over-temperature flag and a raw enable pin. From these inputs it decides when the output counts as good, when the converter must stop switching, and which events go to an interrupt line.

Power-good uses two nested windows. The inner ±5% window must hold for a qualification time, counted in clocks, before power-good rises. Only an excursion beyond the wider ±7.5% window that lasts past one switching cycle takes it down again. The block latches over-voltage and over-current faults, and each has its own clear rule. All thresholds are exact integer comparisons: both codes are scaled by small constants built from shifts and adds.

Top module: `pwr_supervisor`

## Requirements
- R1: With the converter running (enable high after synchronization and no gate-off cause), `pg_good` rises after exactly `QUAL_CYC` consecutive clock samples in which 38·ref ≤ 40·fb ≤ 42·ref. Any sample outside that range restarts the count.
- R2: Once good, the status holds while 37·ref ≤ 40·fb ≤ 43·ref. Outside that range, it falls at the second `sw_tick` seen while feedback stays outside. A return inside the range resets the tick count.
- R3: With `pg_mask` high, `pg_good` stays low and a window excursion does not set status bit 3.
- R4: When 40·fb > 56·ref, `ov_fault` sets one clock later and stays set through enable toggles. Only `rst` clears it.
- R5: A switching cycle is tripped if `ilim_trip` pulsed at any clock of that cycle, up to and including its `sw_tick`. At the `sw_tick` that closes the fifth consecutive tripped cycle, `oc_fault` sets. A cycle with no trip restarts the run.
- R6: `oc_fault` clears on the third clock after `en_raw` goes low (two-stage synchronizer plus one register), or on `rst`.
- R7: `gate_off` is high while the synchronized enable is low, while `ov_fault` or `oc_fault` is set, or while `otp_flag` is high. Enable takes effect two clocks after `en_raw` changes.
- R8: When `otp_flag` falls, `discharge_req` is high for exactly the one clock that follows.
- R9: The bits of `irq_status` are sticky and each sets one clock after its source: bit0 over-voltage latched, bit1 synchronized enable fell, bit2 over-temperature active, bit3 power-good dropped by window excursion, bit4 internal limit trip, bit5 `xlim_trip`, bit6 reference code decreased. Writing 1 on `irq_clr` clears a bit, but a source active in the same clock wins.
- R10: `irq` is the OR of the `irq_status` bits whose `irq_mask` bit is 0. Masking never alters `irq_status`.
- R11: After `rst`, `pg_good`, `ov_fault`, `oc_fault`, `discharge_req`, `irq_status` and `irq` are 0 and `gate_off` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| en_raw | input | 1 | Unsynchronized enable |
| fb_code | input | FB_W | Digitized feedback code |
| ref_code | input | FB_W | Present reference code |
| sw_tick | input | 1 | One-clock pulse closing each switching cycle |
| ilim_trip | input | 1 | Peak-current-limit trip pulse |
| xlim_trip | input | 1 | External current-limit comparator event |
| otp_flag | input | 1 | Over-temperature flag, hysteresis applied upstream |
| pg_mask | input | 1 | Suppress power-good action and indication |
| irq_mask | input | 7 | Per-source interrupt mask, 1 = masked |
| irq_clr | input | 7 | Write-1-to-clear strobes for status bits |
| pg_good | output | 1 | Power-good status |
| ov_fault | output | 1 | Latched over-voltage fault |
| oc_fault | output | 1 | Latched over-current fault |
| gate_off | output | 1 | Force all switches off |
| discharge_req | output | 1 | One-clock output discharge request |
| irq_status | output | 7 | Sticky interrupt status bits |
| irq | output | 1 | Interrupt request |

## Verification
Most results are due one clock after their cause: fault latches, status bits and the discharge pulse. Power-good rises on the `QUAL_CYC`-th qualifying edge and falls on the second outside tick. Anything that depends on enable waits for the two synchronizer stages, and the enable-driven clear of the over-current latch lands on the third edge. The bench drives on falling edges and steps an exact number of rising edges before it samples. It probes both sides of every due edge: one edge early it expects the old value, on the due edge the new one. Randomized feedback/reference pairs are held well past qualification and then compared against the window and over-voltage predicates that the bench computes itself.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    localparam int NSRC     = 7;
    localparam int SRC_OV   = 0;
    localparam int SRC_OFF  = 1;
    localparam int SRC_HOT  = 2;
    localparam int SRC_PGX  = 3;
    localparam int SRC_ILIM = 4;
    localparam int SRC_XLIM = 5;
    localparam int SRC_DROP = 6;

    // scale factors, all over a common denominator of 40
    localparam logic [5:0] K_FB     = 6'd40;
    localparam logic [5:0] K_IN_HI  = 6'd42;
    localparam logic [5:0] K_IN_LO  = 6'd38;
    localparam logic [5:0] K_OUT_HI = 6'd43;
    localparam logic [5:0] K_OUT_LO = 6'd37;
    localparam logic [5:0] K_OV     = 6'd56;

    typedef struct packed {
        logic in_inner;
        logic in_outer;
        logic over_v;
    } win_t;

    // constant multiply by shift-and-add
    function automatic logic [31:0] cmul(input logic [31:0] x, input logic [5:0] k);
        logic [31:0] acc;
        acc = '0;
        for (int i = 0; i < 6; i++) begin
            if (k[i]) acc = acc + (x << i);
        end
        return acc;
    endfunction

endpackage

// File: rtl/pgs_window.sv
module pgs_window
    import pgs_pkg::*;
#(
    parameter int W = 9
) (
    input  logic [W-1:0] fb_code,
    input  logic [W-1:0] ref_code,
    output win_t         win
);
    logic [31:0] fb_s, lo_in, hi_in, lo_out, hi_out, ov_th;

    always_comb begin
        fb_s   = cmul(32'(fb_code), K_FB);
        lo_in  = cmul(32'(ref_code), K_IN_LO);
        hi_in  = cmul(32'(ref_code), K_IN_HI);
        lo_out = cmul(32'(ref_code), K_OUT_LO);
        hi_out = cmul(32'(ref_code), K_OUT_HI);
        ov_th  = cmul(32'(ref_code), K_OV);
        win.in_inner = (fb_s >= lo_in)  && (fb_s <= hi_in);
        win.in_outer = (fb_s >= lo_out) && (fb_s <= hi_out);
        win.over_v   = (fb_s > ov_th);
    end
endmodule

// File: rtl/pgs_pg_qual.sv
module pgs_pg_qual #(
    parameter int QUAL_CYC = 165000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic in_inner,
    input  logic in_outer,
    input  logic sw_tick,
    output logic pg_st,
    output logic drop_evt
);
    localparam int QW = $clog2(QUAL_CYC + 1);

    logic [QW-1:0] cnt;
    logic          out_seen;

    assign drop_evt = pg_st && run && !in_outer && sw_tick && out_seen;

    always_ff @(posedge clk) begin
        if (rst || !run || !in_inner) begin
            cnt <= '0;
        end else if (cnt != QW'(QUAL_CYC)) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run || in_outer) begin
            out_seen <= 1'b0;
        end else if (sw_tick) begin
            out_seen <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run || drop_evt) begin
            pg_st <= 1'b0;
        end else if (in_inner && cnt == QW'(QUAL_CYC - 1)) begin
            pg_st <= 1'b1;
        end
    end
endmodule

// File: rtl/pgs_oc_guard.sv
module pgs_oc_guard #(
    parameter int TRIP_LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic sw_tick,
    input  logic ilim_trip,
    output logic oc_latch
);
    localparam int CW = $clog2(TRIP_LIMIT + 1);

    logic [CW-1:0] run_len;
    logic          trip_seen;
    logic          hit;

    assign hit = trip_seen || ilim_trip;

    always_ff @(posedge clk) begin
        if (rst || !armed || sw_tick) begin
            trip_seen <= 1'b0;
        end else if (ilim_trip) begin
            trip_seen <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            run_len <= '0;
        end else if (sw_tick) begin
            if (!hit) begin
                run_len <= '0;
            end else if (run_len != CW'(TRIP_LIMIT)) begin
                run_len <= run_len + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            oc_latch <= 1'b0;
        end else if (sw_tick && hit && run_len == CW'(TRIP_LIMIT)) begin
            oc_latch <= 1'b1;
        end
    end
endmodule

// File: rtl/pgs_irq.sv
module pgs_irq #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                status[i] <= 1'b0;
            end else if (set_vec[i]) begin
                status[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                status[i] <= 1'b0;
            end
        end
    end

    assign irq = |(status & ~mask);
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
    import pgs_pkg::*;
#(
    parameter int FB_W       = 9,
    parameter int QUAL_CYC   = 165000,
    parameter int TRIP_LIMIT = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_raw,
    input  logic [FB_W-1:0] fb_code,
    input  logic [FB_W-1:0] ref_code,
    input  logic            sw_tick,
    input  logic            ilim_trip,
    input  logic            xlim_trip,
    input  logic            otp_flag,
    input  logic            pg_mask,
    input  logic [NSRC-1:0] irq_mask,
    input  logic [NSRC-1:0] irq_clr,
    output logic            pg_good,
    output logic            ov_fault,
    output logic            oc_fault,
    output logic            gate_off,
    output logic            discharge_req,
    output logic [NSRC-1:0] irq_status,
    output logic            irq
);
    logic            en_m, en_s, en_q;
    logic            otp_q;
    logic [FB_W-1:0] ref_q;
    win_t            win;
    logic            run, pg_st, drop_evt;
    logic [NSRC-1:0] set_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_m          <= 1'b0;
            en_s          <= 1'b0;
            en_q          <= 1'b0;
            otp_q         <= 1'b0;
            ref_q         <= '0;
            ov_fault      <= 1'b0;
            discharge_req <= 1'b0;
        end else begin
            en_m          <= en_raw;
            en_s          <= en_m;
            en_q          <= en_s;
            otp_q         <= otp_flag;
            ref_q         <= ref_code;
            ov_fault      <= ov_fault || win.over_v;
            discharge_req <= otp_q && !otp_flag;
        end
    end

    pgs_window #(.W(FB_W)) i_win (
        .fb_code (fb_code),
        .ref_code(ref_code),
        .win     (win)
    );

    assign gate_off = !en_s || ov_fault || oc_fault || otp_flag;
    assign run      = !gate_off;

    pgs_pg_qual #(.QUAL_CYC(QUAL_CYC)) i_pgq (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .in_inner(win.in_inner),
        .in_outer(win.in_outer),
        .sw_tick (sw_tick),
        .pg_st   (pg_st),
        .drop_evt(drop_evt)
    );

    pgs_oc_guard #(.TRIP_LIMIT(TRIP_LIMIT)) i_ocg (
        .clk      (clk),
        .rst      (rst),
        .armed    (en_s),
        .sw_tick  (sw_tick),
        .ilim_trip(ilim_trip),
        .oc_latch (oc_fault)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[SRC_OV]   = ov_fault;
        set_vec[SRC_OFF]  = en_q && !en_s;
        set_vec[SRC_HOT]  = otp_flag;
        set_vec[SRC_PGX]  = drop_evt && !pg_mask;
        set_vec[SRC_ILIM] = ilim_trip;
        set_vec[SRC_XLIM] = xlim_trip;
        set_vec[SRC_DROP] = ref_code < ref_q;
    end

    pgs_irq #(.N(NSRC)) i_irq (
        .clk    (clk),
        .rst    (rst),
        .set_vec(set_vec),
        .clr_vec(irq_clr),
        .mask   (irq_mask),
        .status (irq_status),
        .irq    (irq)
    );

    assign pg_good = pg_st && !pg_mask;
endmodule

// File: rtl/pgs_chk.sv
module pgs_chk
    import pgs_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            en_s,
    input logic            sw_tick,
    input logic            ov_fault,
    input logic            oc_fault,
    input logic            gate_off,
    input logic            pg_good,
    input logic            discharge_req,
    input logic [NSRC-1:0] irq_status,
    input logic [NSRC-1:0] irq_clr
);
    // R4
    ov_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ov_fault |=> ov_fault);

    // R5
    oc_at_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oc_fault) |-> $past(sw_tick));

    // R6
    oc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(oc_fault) |-> $past(!en_s));

    // R8
    discharge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        discharge_req |=> !discharge_req);

    // R9
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(irq_status) & ~irq_status & ~$past(irq_clr)) == '0));

    // R1
    pg_rise_running_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_good) |-> !gate_off);
endmodule

bind pwr_supervisor pgs_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .en_s         (en_s),
    .sw_tick      (sw_tick),
    .ov_fault     (ov_fault),
    .oc_fault     (oc_fault),
    .gate_off     (gate_off),
    .pg_good      (pg_good),
    .discharge_req(discharge_req),
    .irq_status   (irq_status),
    .irq_clr      (irq_clr)
);

// File: tb/test_pwr_supervisor.sv
module test_pwr_supervisor;
    localparam int FB_W = 9;
    localparam int QUAL = 40;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en_raw = 1'b0;
    logic [FB_W-1:0] fb_code = '0;
    logic [FB_W-1:0] ref_code = 9'd200;
    logic            sw_tick = 1'b0, ilim_trip = 1'b0, xlim_trip = 1'b0, otp_flag = 1'b0;
    logic            pg_mask = 1'b0;
    logic [6:0]      irq_mask = '0, irq_clr = '0;
    logic            pg_good, ov_fault, oc_fault, gate_off, discharge_req, irq;
    logic [6:0]      irq_status;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_supervisor #(.FB_W(FB_W), .QUAL_CYC(QUAL), .TRIP_LIMIT(4)) i_pwr_supervisor (
        .clk(clk), .rst(rst), .en_raw(en_raw), .fb_code(fb_code), .ref_code(ref_code),
        .sw_tick(sw_tick), .ilim_trip(ilim_trip), .xlim_trip(xlim_trip), .otp_flag(otp_flag),
        .pg_mask(pg_mask), .irq_mask(irq_mask), .irq_clr(irq_clr),
        .pg_good(pg_good), .ov_fault(ov_fault), .oc_fault(oc_fault), .gate_off(gate_off),
        .discharge_req(discharge_req), .irq_status(irq_status), .irq(irq)
    );

    function automatic bit exp_inner(int fb, int rf);
        return (fb * 40 >= rf * 38) && (fb * 40 <= rf * 42);
    endfunction

    function automatic bit exp_ov(int fb, int rf);
        return fb * 40 > rf * 56;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; en_raw = 1'b0; fb_code = '0; ref_code = 9'd200;
        sw_tick = 0; ilim_trip = 0; xlim_trip = 0; otp_flag = 0;
        pg_mask = 0; irq_mask = '0; irq_clr = '0;
        step(2);
        rst = 1'b0;
    endtask

    task automatic enable_on();
        en_raw = 1'b1;
        step(3);
    endtask

    task automatic tick();
        sw_tick = 1'b1; step(1); sw_tick = 1'b0; step(1);
    endtask

    task automatic trip_tick();
        ilim_trip = 1'b1; sw_tick = 1'b1; step(1);
        ilim_trip = 1'b0; sw_tick = 1'b0; step(1);
    endtask

    task automatic trip_mid();
        ilim_trip = 1'b1; step(1); ilim_trip = 1'b0; step(1);
        sw_tick = 1'b1; step(1); sw_tick = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL R11 watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);

        // R11 reset state
        do_reset();
        chk("R11 pg", pg_good, 0);
        chk("R11 ov", ov_fault, 0);
        chk("R11 oc", oc_fault, 0);
        chk("R11 gate_off", gate_off, 1);
        chk("R11 status", irq_status, 0);
        chk("R11 irq", irq, 0);
        chk("R11 discharge", discharge_req, 0);

        // R7 enable path: two clocks of synchronization
        en_raw = 1'b1; step(1);
        chk("R7 gate_off one edge", gate_off, 1);
        step(1);
        chk("R7 gate_off released", gate_off, 0);
        step(1);

        // R1 qualification, interrupted count, inclusive boundary
        fb_code = 9'd200; step(10);
        fb_code = 9'd189; step(1);
        fb_code = 9'd190; step(QUAL - 1);
        chk("R1 pg before qual", pg_good, 0);
        step(1);
        chk("R1 pg after qual", pg_good, 1);

        // R2 hold between windows, outer edge inclusive, interrupted excursion
        fb_code = 9'd212; tick(); tick(); tick();
        chk("R2 hold between windows", pg_good, 1);
        fb_code = 9'd215; tick(); tick();
        chk("R2 hold at outer edge", pg_good, 1);
        fb_code = 9'd216; tick();
        fb_code = 9'd200; step(1);
        fb_code = 9'd216; tick();
        chk("R2 interrupted excursion", pg_good, 1);
        fb_code = 9'd200; step(1);
        fb_code = 9'd216; sw_tick = 1'b1; step(1); sw_tick = 1'b0; step(1);
        chk("R2 one tick outside", pg_good, 1);
        sw_tick = 1'b1; step(1); sw_tick = 1'b0;
        chk("R2 drop on second tick", pg_good, 0);
        chk("R9 window bit3", irq_status[3], 1);
        chk("R10 irq from bit3", irq, 1);

        // R3 power-good mask
        do_reset(); fb_code = 9'd200; pg_mask = 1'b1; enable_on();
        step(QUAL + 2);
        chk("R3 pg masked", pg_good, 0);
        fb_code = 9'd216; tick(); tick(); tick();
        chk("R3 no bit3 when masked", irq_status[3], 0);

        // R4 over-voltage latch
        do_reset(); enable_on();
        fb_code = 9'd280; step(2);
        chk("R4 at 1.4x no trip", ov_fault, 0);
        fb_code = 9'd281; step(1);
        chk("R4 ov latched", ov_fault, 1);
        chk("R7 gate_off by ov", gate_off, 1);
        fb_code = 9'd0; step(1);
        chk("R9 ov bit0", irq_status[0], 1);
        en_raw = 1'b0; step(3); en_raw = 1'b1; step(3);
        chk("R4 enable toggle keeps ov", ov_fault, 1);
        do_reset(); step(1);
        chk("R4 rst clears ov", ov_fault, 0);

        // R5 over-current run length
        do_reset(); fb_code = 9'd200; enable_on();
        repeat (4) trip_tick();
        tick();
        trip_mid(); step(1); trip_mid(); step(1); trip_mid(); step(1); trip_mid(); step(1);
        chk("R5 four trips no latch", oc_fault, 0);
        chk("R9 ilim bit4", irq_status[4], 1);
        ilim_trip = 1'b1; sw_tick = 1'b1; step(1);
        ilim_trip = 1'b0; sw_tick = 1'b0;
        chk("R5 fifth trip latches", oc_fault, 1);
        chk("R7 gate_off by oc", gate_off, 1);

        // R6 clear by enable low
        en_raw = 1'b0; step(2);
        chk("R6 oc held two edges", oc_fault, 1);
        step(1);
        chk("R6 oc cleared", oc_fault, 0);
        chk("R9 enable-off bit1", irq_status[1], 1);
        en_raw = 1'b1; step(3);
        chk("R7 running again", gate_off, 0);

        // R7/R8 thermal
        otp_flag = 1'b1; step(1);
        chk("R7 gate_off by otp", gate_off, 1);
        chk("R9 thermal bit2", irq_status[2], 1);
        otp_flag = 1'b0; step(1);
        chk("R8 discharge pulse", discharge_req, 1);
        step(1);
        chk("R8 discharge one clock", discharge_req, 0);

        // R9 clear and set-wins
        irq_clr = 7'h04; step(1); irq_clr = '0;
        chk("R9 W1C bit2", irq_status[2], 0);
        otp_flag = 1'b1; irq_clr = 7'h04; step(1); irq_clr = '0; otp_flag = 1'b0;
        chk("R9 set wins", irq_status[2], 1);
        step(1);
        xlim_trip = 1'b1; step(1); xlim_trip = 1'b0;
        chk("R9 xlim bit5", irq_status[5], 1);
        irq_clr = 7'h40; step(1); irq_clr = '0;
        ref_code = 9'd190; step(1);
        chk("R9 ref drop bit6", irq_status[6], 1);
        irq_clr = 7'h40; step(1); irq_clr = '0;
        ref_code = 9'd200; step(2);
        chk("R9 ref rise no bit6", irq_status[6], 0);

        // R10 masking
        irq_mask = 7'h7F; step(1);
        chk("R10 all masked", irq, 0);
        chk("R10 status kept", (irq_status != 0), 1);
        irq_mask = ~irq_status; step(1);
        chk("R10 unmasked bit", irq, 1);
        irq_mask = '0; irq_clr = 7'h7F; step(1); irq_clr = '0;
        chk("R10 all cleared", irq, 0);

        // R1/R4 random feedback and reference pairs
        for (int it = 0; it < 40; it++) begin
            int rf;
            int fb;
            do_reset();
            rf = 30 + int'($urandom % 226);
            if ($urandom % 2 == 1) fb = rf - rf / 10 + int'($urandom % (rf / 5 + 1));
            else fb = int'($urandom % 512);
            if (fb > 511) fb = 511;
            ref_code = FB_W'(rf); fb_code = FB_W'(fb);
            enable_on();
            step(QUAL + 1);
            chk("R4 random ov", ov_fault, exp_ov(fb, rf));
            chk("R1 random pg", pg_good, exp_inner(fb, rf) && !exp_ov(fb, rf));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule